// File: doc/BRIEF.md
# Priority Operand Forwarding Unit

This block is the forwarding control for the execute stage of a five-stage pipeline. It works before the ALU computes. It takes the two source register numbers of the instruction now in execute and compares them with the destination registers held in the EX/MEM and MEM/WB pipeline registers. From these comparisons it drives one select code for each ALU operand multiplexer. The code picks the register file value, the EX/MEM result or the MEM/WB result. The block is purely combinational. It only makes the choice; it does not carry the data.

An instruction-class input decides which operands are compared. Register-register operations and branches check both sources. Loads, stores and immediate operations check only the first source. A class with no register sources checks neither. When both later stages hold the register, the EX/MEM result wins because it is the newer one. A stage can forward only when its write-enable bit is set and its destination is not register 0.

Top module: `fwd_select`

## Requirements
- R1: With class code 2'b00 (register-register), each of operand A (from `src_a`) and operand B (from `src_b`) is compared against both the EX/MEM and the MEM/WB destination.
- R2: With class code 2'b01 (load, store or immediate), only operand A is compared; `sel_b` stays 2'b00 whatever the destinations are.
- R3: With class code 2'b10 (branch), both compared registers are checked, the same way as in R1.
- R4: With class code 2'b11 (no register source), both selects stay 2'b00.
- R5: When EX/MEM and MEM/WB both match the same operand, that operand's select is 2'b10 (EX/MEM), because EX/MEM holds the newer result.
- R6: An operand gets 2'b01 (MEM/WB) only when EX/MEM does not match that same operand. The other operand may still take EX/MEM on its own match.
- R7: A stage whose write-enable input is 0 never causes a forward.
- R8: A destination equal to register 0 never causes a forward, even when write-enable is set and the source is also 0.
- R9: The select codes are 2'b00 for the register file, 2'b10 for EX/MEM and 2'b01 for MEM/WB. The code 2'b11 never appears. The outputs follow the inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_class | input | 2 | Class of the instruction in execute (see R1 to R4) |
| src_a | input | REG_AW | First source register number |
| src_b | input | REG_AW | Second source register number |
| exm_wen | input | 1 | EX/MEM register-write control bit |
| exm_dst | input | REG_AW | EX/MEM destination register |
| mwb_wen | input | 1 | MEM/WB register-write control bit |
| mwb_dst | input | REG_AW | MEM/WB destination register |
| sel_a | output | 2 | Operand A multiplexer select |
| sel_b | output | 2 | Operand B multiplexer select |

## Verification
Both selects are combinational, so each result is due in the same cycle its inputs are applied, with no delay in cycles. The driver applies a stimulus just after a rising edge and queues the expected pair of selects at the same time. The monitor pops the queue and compares at the following falling edge, half a period later, when the inputs are steady. So every item is checked in its own cycle, and no two stimuli share a comparison.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int REG_AW = 5
) (
  input  logic [1:0]        ex_class,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic              exm_wen,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              mwb_wen,
  input  logic [REG_AW-1:0] mwb_dst,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);
  localparam logic [1:0] CLS_RR   = 2'b00;
  localparam logic [1:0] CLS_MEMI = 2'b01;
  localparam logic [1:0] CLS_BR   = 2'b10;
  localparam logic [1:0] CLS_NONE = 2'b11;
  localparam logic [1:0] SEL_RF   = 2'b00;
  localparam logic [1:0] SEL_EXM  = 2'b10;
  localparam logic [1:0] SEL_MWB  = 2'b01;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic chk_a, chk_b, exm_live, mwb_live;
  logic exm_a, exm_b, mwb_a, mwb_b;

  assign chk_a = (ex_class != CLS_NONE);
  assign chk_b = (ex_class == CLS_RR) || (ex_class == CLS_BR);

  assign exm_live = exm_wen && (exm_dst != ZERO_REG);
  assign mwb_live = mwb_wen && (mwb_dst != ZERO_REG);

  assign exm_a = chk_a && exm_live && (exm_dst == src_a);
  assign exm_b = chk_b && exm_live && (exm_dst == src_b);
  assign mwb_a = chk_a && mwb_live && (mwb_dst == src_a);
  assign mwb_b = chk_b && mwb_live && (mwb_dst == src_b);

  assign sel_a = exm_a ? SEL_EXM : (mwb_a ? SEL_MWB : SEL_RF);
  assign sel_b = exm_b ? SEL_EXM : (mwb_b ? SEL_MWB : SEL_RF);

  always_comb begin
    if (!$isunknown({ex_class, src_a, src_b, exm_wen, exm_dst, mwb_wen, mwb_dst})) begin
      AST_B_IDLE_MEMI: assert (!(ex_class == CLS_MEMI) || sel_b == SEL_RF); // R2
      AST_NONE_IDLE: assert (!(ex_class == CLS_NONE) || (sel_a == SEL_RF && sel_b == SEL_RF)); // R4
      AST_NEWEST_WINS: assert (!(chk_a && exm_wen && exm_dst == src_a && src_a != ZERO_REG) || sel_a == SEL_EXM); // R5
      AST_NO_WRITERS: assert (exm_wen || mwb_wen || (sel_a == SEL_RF && sel_b == SEL_RF)); // R7
      AST_REG0_LOCAL: assert (src_a != ZERO_REG || sel_a == SEL_RF); // R8
      AST_NO_CODE11: assert ($onehot0(sel_a) && $onehot0(sel_b)); // R9
    end
  end
endmodule

// File: tb/test_fwd_select.sv
`timescale 1ns/1ps
module test_fwd_select;
  localparam int AW = 5;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]    ex_class = 2'b00;
  logic [AW-1:0] src_a = '0, src_b = '0, exm_dst = '0, mwb_dst = '0;
  logic          exm_wen = 1'b0, mwb_wen = 1'b0;
  logic [1:0]    sel_a, sel_b;

  fwd_select #(.REG_AW(AW)) i_fwd_select (
    .ex_class(ex_class), .src_a(src_a), .src_b(src_b),
    .exm_wen(exm_wen), .exm_dst(exm_dst),
    .mwb_wen(mwb_wen), .mwb_dst(mwb_dst),
    .sel_a(sel_a), .sel_b(sel_b));

  typedef struct { logic [1:0] a; logic [1:0] b; string req; } exp_t;
  exp_t sb[$];
  int n_total = 0, n_pass = 0;
  bit done = 0;

  function automatic logic [1:0] model(input logic chk, input logic [AW-1:0] s,
      input logic ew, input logic [AW-1:0] ed, input logic mw, input logic [AW-1:0] md);
    if (chk && ew && ed != 0 && ed == s) return 2'b10;
    if (chk && mw && md != 0 && md == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input logic [1:0] c, input logic [AW-1:0] a, input logic [AW-1:0] b,
      input logic ew, input logic [AW-1:0] ed, input logic mw, input logic [AW-1:0] md,
      input logic [1:0] ea, input logic [1:0] eb, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    ex_class = c; src_a = a; src_b = b;
    exm_wen = ew; exm_dst = ed; mwb_wen = mw; mwb_dst = md;
    e.a = ea; e.b = eb; e.req = req;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        n_total++;
        if (sel_a === e.a && sel_b === e.b) n_pass++;
        else $display("FAIL %s: sel_a/sel_b = %b/%b, expected %b/%b", e.req, sel_a, sel_b, e.a, e.b);
      end
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R9 idle");
    // R1 register-register
    drive(2'b00, 3, 4, 1, 3, 1, 4, 2'b10, 2'b01, "R1 A exm B mwb");
    drive(2'b00, 7, 9, 1, 9, 1, 7, 2'b01, 2'b10, "R1 A mwb B exm");
    drive(2'b00, 5, 5, 1, 5, 0, 0, 2'b10, 2'b10, "R1 both exm");
    drive(2'b00, 1, 2, 1, 6, 1, 8, 2'b00, 2'b00, "R1 no match");
    // R2 mem/imm
    drive(2'b01, 3, 4, 1, 4, 1, 4, 2'b00, 2'b00, "R2 B ignored");
    drive(2'b01, 3, 4, 1, 3, 1, 4, 2'b10, 2'b00, "R2 A only");
    drive(2'b01, 6, 6, 0, 6, 1, 6, 2'b01, 2'b00, "R2 A mwb");
    // R3 branch
    drive(2'b10, 11, 12, 1, 12, 1, 11, 2'b01, 2'b10, "R3 both checked");
    // R4 none
    drive(2'b11, 3, 4, 1, 3, 1, 4, 2'b00, 2'b00, "R4 no sources");
    // R5 priority
    drive(2'b00, 10, 10, 1, 10, 1, 10, 2'b10, 2'b10, "R5 exm wins");
    drive(2'b10, 15, 2, 1, 15, 1, 15, 2'b10, 2'b00, "R5 exm wins branch");
    // R6 mwb only when exm misses that operand
    drive(2'b00, 20, 21, 1, 21, 1, 20, 2'b01, 2'b10, "R6 split");
    drive(2'b00, 20, 21, 1, 20, 1, 21, 2'b10, 2'b01, "R6 split swapped");
    // R7 write enable
    drive(2'b00, 3, 4, 0, 3, 0, 4, 2'b00, 2'b00, "R7 no wen");
    drive(2'b00, 3, 3, 0, 3, 1, 3, 2'b01, 2'b01, "R7 exm disabled");
    // R8 register zero
    drive(2'b00, 0, 0, 1, 0, 1, 0, 2'b00, 2'b00, "R8 reg0");
    drive(2'b00, 0, 9, 1, 0, 1, 9, 2'b00, 2'b01, "R8 reg0 A");
    for (int i = 0; i < 300; i++) begin
      logic [1:0] c; logic [AW-1:0] a, b, ed, md; logic ew, mw; logic ca, cb;
      c = 2'($urandom); a = AW'($urandom % 4); b = AW'($urandom % 4);
      ed = AW'($urandom % 4); md = AW'($urandom % 4);
      ew = 1'($urandom); mw = 1'($urandom);
      ca = (c != 2'b11); cb = (c == 2'b00 || c == 2'b10);
      drive(c, a, b, ew, ed, mw, md, model(ca, a, ew, ed, mw, md), model(cb, b, ew, ed, mw, md), "R9 sweep");
    end
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: run hung, actual timeout, expected completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end
endmodule